// File: doc/BRIEF.md
# Fuse Line Write Gating Controller

This block sits in front of a one-time-programmable fuse macro whose lines are 64 bits wide and can only be burned as a whole. Software can only issue 32-bit writes. Each write carries a fuse line number, a word index and a data word. Words 0 and 1 are the upper and lower data halves. Word 2 is the commit-and-lock flag. The controller keeps the halves across separate write transactions. When the commit arrives it turns them into one atomic program-and-lock command. A bare commit on a line with nothing pending becomes a lock-only command, which seals an unused line.

Any sequence that would burn a partial or undefined value is refused with an error response, and no fuse command is issued for it. The controller keeps its own record of which lines are already sealed. It holds pending data for only one line at a time. While the macro is burning, a busy flag is raised and further writes are held off. A write may also be one beat of a multi-word transfer, in which case its word index follows on from the previous beat.

Top module: `fuse_line_gate`

## Requirements
- R1: After reset, wr_ready is 1, busy is 0, and neither fm_cmd_valid nor rsp_valid is asserted.
- R2: An accepted write to word index 0 or 1 of a legal, unsealed line stores that half and issues no fuse command. Its response has rsp_err = 0.
- R3: A word-2 write with data exactly 1, when both halves of that line are pending, issues one program command with fm_cmd_lock_only = 0. The command's 64-bit value is {word0, word1}, with word 0 in bits 63:32. The line then counts as sealed.
- R4: A word-2 write with data 1, when neither half of that line is pending, issues one command with fm_cmd_lock_only = 1 and fm_cmd_data = 0. The line then counts as sealed.
- R5: A word-2 write with data 1, when exactly one half is pending, gets rsp_err = 1 and issues no command. The pending halves are cleared.
- R6: A word-2 write whose data is not exactly 1 gets rsp_err = 1 and issues no command. The pending halves of that line are cleared.
- R7: Any write to a sealed line gets rsp_err = 1, issues no command, and leaves the pending halves unchanged.
- R8: An effective word index above 2, or a line number of NUM_LINES or more, gets rsp_err = 1. Such a write issues no command and leaves the pending halves unchanged.
- R9: A write with wr_first = 1 uses wr_index. A write with wr_first = 0 uses the previous accepted write's effective index plus one, which saturates at 7.
- R10: A legal write to an unsealed line other than the line holding pending halves discards those halves. It raises warn together with its response.
- R11: Every accepted write (wr_valid and wr_ready) produces rsp_valid in the next cycle. A fuse command appears in that same next cycle. From then on, busy is 1 and wr_ready is 0 until the cycle after fm_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Write accepted when high together with wr_valid |
| wr_first | input | 1 | 1: take wr_index; 0: continue the index of the previous beat |
| wr_line | input | LINE_W | Fuse line number |
| wr_index | input | 2 | Word index for a first beat |
| wr_data | input | 32 | Write data word |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response marks a rejected write |
| warn | output | 1 | Pending halves of another line were discarded |
| busy | output | 1 | Fuse macro is working on a command |
| fm_cmd_valid | output | 1 | One-cycle fuse command strobe |
| fm_cmd_lock_only | output | 1 | Command seals the line without programming |
| fm_cmd_line | output | LINE_W | Line of the command |
| fm_cmd_data | output | 64 | Value to burn |
| fm_done | input | 1 | Macro finished the current command |

## Verification
The bench builds the block with NUM_LINES = 6 and LINE_W = 3. With these values, line numbers 6 and 7 exist on the port but are out of range, so the range rejection path can be driven. The six lines also fill up with seals quickly, which exercises rejection of writes to sealed lines. Periodic resets then free the lines again for fresh commit, discard and burst sequences. A macro model answers fm_done after a fixed burn time, so each accepted command holds off the next write for several cycles.

// File: rtl/fgate_pkg.sv
package fgate_pkg;
  typedef enum logic [2:0] {
    ACT_REJECT   = 3'd0,
    ACT_STORE    = 3'd1,
    ACT_PROGRAM  = 3'd2,
    ACT_LOCKONLY = 3'd3
  } fg_act_e;

  localparam int HALF_W = 32;
  localparam int LINE_BITS = 64;
  localparam int IDX_W = 3;

  function automatic logic [LINE_BITS-1:0] join_halves(input logic [HALF_W-1:0] upper,
                                                       input logic [HALF_W-1:0] lower);
    return {upper, lower};
  endfunction

  function automatic logic [IDX_W-1:0] next_index(input logic [IDX_W-1:0] cur);
    return (cur == '1) ? cur : cur + 1'b1;
  endfunction

  function automatic logic idx_legal(input logic [IDX_W-1:0] idx);
    return idx <= 3'd2;
  endfunction
endpackage

// File: rtl/fgate_decode.sv
module fgate_decode
  import fgate_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W = 5
) (
  input  logic [LINE_W-1:0] line,
  input  logic [IDX_W-1:0]  idx,
  input  logic [HALF_W-1:0] data,
  input  logic              line_sealed,
  input  logic              have_upper,
  input  logic              have_lower,
  input  logic [LINE_W-1:0] pend_line,
  output fg_act_e           act,
  output logic              discard,
  output logic              clr_pend
);
  localparam logic [LINE_W:0] LINE_LIM = (LINE_W+1)'(NUM_LINES);

  logic range_ok;
  logic usable;
  logic h_up;
  logic h_lo;

  always_comb begin
    range_ok = idx_legal(idx) && ({1'b0, line} < LINE_LIM);
    usable   = range_ok && !line_sealed;
    discard  = usable && (have_upper || have_lower) && (pend_line != line);
    h_up     = have_upper && !discard;
    h_lo     = have_lower && !discard;
    clr_pend = usable && (idx == 3'd2);
    act      = ACT_REJECT;
    if (usable) begin
      if (idx != 3'd2)               act = ACT_STORE;
      else if (data != 32'd1)        act = ACT_REJECT;
      else if (h_up && h_lo)         act = ACT_PROGRAM;
      else if (!h_up && !h_lo)       act = ACT_LOCKONLY;
      else                           act = ACT_REJECT;
    end
  end
endmodule

// File: rtl/fgate_pending.sv
module fgate_pending
  import fgate_pkg::*;
#(
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              store,
  input  logic              store_lower,
  input  logic              discard,
  input  logic              clr_pend,
  input  logic [LINE_W-1:0] line,
  input  logic [HALF_W-1:0] data,
  output logic              have_upper,
  output logic              have_lower,
  output logic [HALF_W-1:0] upper_q,
  output logic [HALF_W-1:0] lower_q,
  output logic [LINE_W-1:0] pend_line
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_upper <= 1'b0;
      have_lower <= 1'b0;
      upper_q    <= '0;
      lower_q    <= '0;
      pend_line  <= '0;
    end else if (fire) begin
      if (clr_pend) begin
        have_upper <= 1'b0;
        have_lower <= 1'b0;
      end else if (store) begin
        pend_line <= line;
        if (store_lower) begin
          have_lower <= 1'b1;
          lower_q    <= data;
          have_upper <= have_upper && !discard;
        end else begin
          have_upper <= 1'b1;
          upper_q    <= data;
          have_lower <= have_lower && !discard;
        end
      end
    end
  end
endmodule

// File: rtl/fgate_sealmap.sv
module fgate_sealmap #(
  parameter int NUM_LINES = 24,
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seal_en,
  input  logic [LINE_W-1:0] seal_line,
  input  logic [LINE_W-1:0] query_line,
  output logic              query_sealed
);
  localparam int SLOTS = 2 ** LINE_W;

  logic [SLOTS-1:0] sealed_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g < NUM_LINES) begin : g_real
      always_ff @(posedge clk) begin
        if (!rst_n)
          sealed_q[g] <= 1'b0;
        else if (seal_en && (seal_line == LINE_W'(g)))
          sealed_q[g] <= 1'b1;
      end
    end else begin : g_none
      assign sealed_q[g] = 1'b0;
    end
  end

  assign query_sealed = sealed_q[query_line];
endmodule

// File: rtl/fuse_line_gate.sv
module fuse_line_gate
  import fgate_pkg::*;
#(
  parameter int NUM_LINES = 24,
  parameter int LINE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_first,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [1:0]        wr_index,
  input  logic [31:0]       wr_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              warn,
  output logic              busy,
  output logic              fm_cmd_valid,
  output logic              fm_cmd_lock_only,
  output logic [LINE_W-1:0] fm_cmd_line,
  output logic [63:0]       fm_cmd_data,
  input  logic              fm_done
);
  logic [IDX_W-1:0]  nxt_idx_q;
  logic [IDX_W-1:0]  eff_idx;
  logic              busy_q;
  logic              fire;
  logic              issue;
  logic              line_sealed;
  logic              have_upper;
  logic              have_lower;
  logic [HALF_W-1:0] upper_q;
  logic [HALF_W-1:0] lower_q;
  logic [LINE_W-1:0] pend_line;
  fg_act_e           act;
  logic              discard;
  logic              clr_pend;

  assign eff_idx  = wr_first ? {1'b0, wr_index} : nxt_idx_q;
  assign wr_ready = !busy_q;
  assign busy     = busy_q;
  assign fire     = wr_valid && !busy_q;
  assign issue    = fire && ((act == ACT_PROGRAM) || (act == ACT_LOCKONLY));

  fgate_decode #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_decode (
    .line        (wr_line),
    .idx         (eff_idx),
    .data        (wr_data),
    .line_sealed (line_sealed),
    .have_upper  (have_upper),
    .have_lower  (have_lower),
    .pend_line   (pend_line),
    .act         (act),
    .discard     (discard),
    .clr_pend    (clr_pend)
  );

  fgate_pending #(.LINE_W(LINE_W)) u_pending (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .store       (act == ACT_STORE),
    .store_lower (eff_idx[0]),
    .discard     (discard),
    .clr_pend    (clr_pend),
    .line        (wr_line),
    .data        (wr_data),
    .have_upper  (have_upper),
    .have_lower  (have_lower),
    .upper_q     (upper_q),
    .lower_q     (lower_q),
    .pend_line   (pend_line)
  );

  fgate_sealmap #(.NUM_LINES(NUM_LINES), .LINE_W(LINE_W)) u_seal (
    .clk          (clk),
    .rst_n        (rst_n),
    .seal_en      (issue),
    .seal_line    (wr_line),
    .query_line   (wr_line),
    .query_sealed (line_sealed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nxt_idx_q        <= '0;
      busy_q           <= 1'b0;
      rsp_valid        <= 1'b0;
      rsp_err          <= 1'b0;
      warn             <= 1'b0;
      fm_cmd_valid     <= 1'b0;
      fm_cmd_lock_only <= 1'b0;
      fm_cmd_line      <= '0;
      fm_cmd_data      <= '0;
    end else begin
      rsp_valid    <= fire;
      rsp_err      <= fire && (act == ACT_REJECT);
      warn         <= fire && discard;
      fm_cmd_valid <= issue;
      if (fire) nxt_idx_q <= next_index(eff_idx);
      if (issue) begin
        busy_q           <= 1'b1;
        fm_cmd_lock_only <= (act == ACT_LOCKONLY);
        fm_cmd_line      <= wr_line;
        fm_cmd_data      <= (act == ACT_PROGRAM) ? join_halves(upper_q, lower_q) : '0;
      end else if (fm_done) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fgate_checker.sv
module fgate_checker (
  input logic clk,
  input logic rst_n,
  input logic fire,
  input logic wr_ready,
  input logic busy,
  input logic rsp_valid,
  input logic rsp_err,
  input logic warn,
  input logic fm_cmd_valid,
  input logic fm_cmd_lock_only,
  input logic [63:0] fm_cmd_data,
  input logic fm_done
);
  a_r11_rsp_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  a_r11_cmd_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    fm_cmd_valid |-> $past(fire));
  a_r11_cmd_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fm_cmd_valid |-> (busy && !wr_ready));
  a_r11_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fm_done && !fm_cmd_valid) |=> busy);
  a_r7_no_cmd_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !fm_cmd_valid);
  a_r10_warn_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    warn |-> rsp_valid);
  a_r4_lockonly_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fm_cmd_valid && fm_cmd_lock_only) |-> (fm_cmd_data == 64'd0));
  a_r3_single_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    fm_cmd_valid |=> !fm_cmd_valid);
endmodule

bind fuse_line_gate fgate_checker u_fgate_checker (
  .clk              (clk),
  .rst_n            (rst_n),
  .fire             (fire),
  .wr_ready         (wr_ready),
  .busy             (busy),
  .rsp_valid        (rsp_valid),
  .rsp_err          (rsp_err),
  .warn             (warn),
  .fm_cmd_valid     (fm_cmd_valid),
  .fm_cmd_lock_only (fm_cmd_lock_only),
  .fm_cmd_data      (fm_cmd_data),
  .fm_done          (fm_done)
);

// File: tb/tb_fuse_line_gate.sv
`timescale 1ns/1ps
module tb_fuse_line_gate;
  localparam int NL = 6;
  localparam int LW = 3;
  localparam int BURN = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_first = 1'b1;
  logic [LW-1:0] wr_line = '0;
  logic [1:0] wr_index = '0;
  logic [31:0] wr_data = '0;
  logic wr_ready, rsp_valid, rsp_err, warn, busy;
  logic fm_cmd_valid, fm_cmd_lock_only;
  logic [LW-1:0] fm_cmd_line;
  logic [63:0] fm_cmd_data;
  logic fm_done = 1'b0;

  always #2 clk = ~clk;

  fuse_line_gate #(.NUM_LINES(NL), .LINE_W(LW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_first(wr_first), .wr_line(wr_line), .wr_index(wr_index), .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .warn(warn), .busy(busy),
    .fm_cmd_valid(fm_cmd_valid), .fm_cmd_lock_only(fm_cmd_lock_only),
    .fm_cmd_line(fm_cmd_line), .fm_cmd_data(fm_cmd_data), .fm_done(fm_done)
  );

  // behavioural fuse array standing in for the macro
  logic [63:0] fuse_val [8];
  int burn_cnt = 0;
  always @(posedge clk) begin
    if (fm_cmd_valid) begin
      burn_cnt <= BURN;
      fm_done  <= 1'b0;
      if (!fm_cmd_lock_only) fuse_val[fm_cmd_line] <= fm_cmd_data;
    end else if (burn_cnt != 0) begin
      burn_cnt <= burn_cnt - 1;
      fm_done  <= (burn_cnt == 1);
    end else begin
      fm_done <= 1'b0;
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done_flag = 0;

  // bench model state
  bit m_seal [8];
  bit m_hu, m_hl;
  logic [31:0] m_up, m_lo;
  int m_pline;
  int m_nidx;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic do_reset();
    wr_valid = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    foreach (m_seal[i]) m_seal[i] = 0;
    m_hu = 0; m_hl = 0; m_pline = 0; m_nidx = 0;
    repeat (BURN + 3) @(negedge clk);
  endtask

  task automatic do_write(input int line, input int idx, input bit first, input logic [31:0] data);
    int eidx, w;
    bit ok, usable, disc, hu, hl, e_err, e_cmd, e_lock;
    logic [63:0] e_data;
    eidx = first ? idx : m_nidx;
    m_nidx = (eidx >= 7) ? 7 : eidx + 1;
    ok = (eidx <= 2) && (line < NL);
    usable = ok && !m_seal[line];
    disc = usable && (m_hu || m_hl) && (m_pline != line);
    hu = m_hu && !disc; hl = m_hl && !disc;
    e_err = 1; e_cmd = 0; e_lock = 0; e_data = 64'd0;
    if (usable) begin
      if (eidx < 2) begin
        e_err = 0;
        m_pline = line;
        if (eidx == 0) begin m_up = data; m_hu = 1; m_hl = hl; end
        else begin m_lo = data; m_hl = 1; m_hu = hu; end
      end else begin
        if (data == 32'd1 && hu && hl) begin e_err = 0; e_cmd = 1; e_data = {m_up, m_lo}; end
        else if (data == 32'd1 && !hu && !hl) begin e_err = 0; e_cmd = 1; e_lock = 1; end
        if (e_cmd) m_seal[line] = 1;
        m_hu = 0; m_hl = 0;
      end
    end
    w = 0;
    while (!wr_ready) begin
      @(negedge clk);
      w++;
      if (w > BURN + 4) begin
        chk("R11 ready_return", 64'(w), 64'(BURN + 4));
        break;
      end
    end
    wr_valid = 1'b1; wr_first = first; wr_line = LW'(line);
    wr_index = 2'(idx); wr_data = data;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    chk("R11 rsp_valid", 64'(rsp_valid), 64'd1);
    chk(eidx > 2 || line >= NL ? "R8 rsp_err" : "R2-7 rsp_err", 64'(rsp_err), 64'(e_err));
    chk("R10 warn", 64'(warn), 64'(disc));
    chk("R3/R4 cmd_valid", 64'(fm_cmd_valid), 64'(e_cmd));
    if (e_cmd && fm_cmd_valid) begin
      chk("R4 lock_only", 64'(fm_cmd_lock_only), 64'(e_lock));
      chk("R3 cmd_line", 64'(fm_cmd_line), 64'(line));
      chk("R3 cmd_data", fm_cmd_data, e_data);
      chk("R11 busy", 64'(busy), 64'd1);
      chk("R11 not_ready", 64'(wr_ready), 64'd0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R1 reset state
    chk("R1 wr_ready", 64'(wr_ready), 64'd1);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 cmd", 64'(fm_cmd_valid), 64'd0);
    chk("R1 rsp", 64'(rsp_valid), 64'd0);
    // R2, R3 program
    do_write(1, 0, 1, 32'h0011_2233);
    do_write(1, 1, 1, 32'h4455_6677);
    do_write(1, 2, 1, 32'd1);
    // R7 sealed line
    do_write(1, 0, 1, 32'hdead_beef);
    // R4 lock only
    do_write(2, 2, 1, 32'd1);
    // R5 partial commit then cleared
    do_write(3, 0, 1, 32'hcafe_0001);
    do_write(3, 2, 1, 32'd1);
    do_write(3, 2, 1, 32'd1);
    // R6 bad flag value clears pending
    do_write(4, 1, 1, 32'h1111_2222);
    do_write(4, 2, 1, 32'd5);
    do_write(4, 0, 1, 32'h3333_4444);
    do_write(4, 2, 1, 32'd1);
    do_write(4, 2, 1, 32'd1);
    // R8 range errors keep pending
    do_write(0, 0, 1, 32'hf0f0_f0f0);
    do_write(7, 1, 1, 32'h9999_9999);
    do_write(6, 0, 1, 32'h8888_8888);
    do_write(0, 3, 1, 32'h7777_7777);
    do_write(0, 1, 1, 32'h0f0f_0f0f);
    do_write(0, 2, 1, 32'd1);
    // R9 burst beats
    do_write(5, 0, 1, 32'h1234_5678);
    do_write(5, 0, 0, 32'h9abc_def0);
    do_write(5, 0, 0, 32'd1);
    do_write(5, 0, 0, 32'd1);
    chk("R3 fuse_array", fuse_val[1], 64'h0011_2233_4455_6677);
    chk("R9 fuse_array", fuse_val[5], 64'h1234_5678_9abc_def0);
    // R10 discard
    do_reset();
    do_write(0, 0, 1, 32'haaaa_0000);
    do_write(1, 0, 1, 32'hbbbb_0000);
    do_write(1, 1, 1, 32'hbbbb_1111);
    do_write(1, 2, 1, 32'd1);
    do_write(0, 2, 1, 32'd1);
    // constrained random
    for (int k = 0; k < 400; k++) begin
      int ln, ix;
      bit fs;
      logic [31:0] dv;
      if (k % 50 == 49) do_reset();
      ln = ($urandom % 8 < 6) ? int'($urandom % 3) : int'($urandom % 8);
      ix = int'($urandom % 4);
      fs = ($urandom % 5) != 0;
      dv = ($urandom % 4 != 0) ? 32'd1 : $urandom;
      if (ix < 2 && fs) dv = $urandom;
      do_write(ln, ix, fs, dv);
    end
    done_flag = 1;
    finish_run();
  end
endmodule